// File: doc/BRIEF.md
# Batched Register Access Engine

This block executes one batched access command against a byte-wide register port. A command arrives as a mode code, a byte count and a 16-byte write buffer. The buffer holds packed little-endian entries. Each entry carries a 16-bit register address. A write entry adds a data byte. A read-modify-write entry adds a data byte and then a mask byte. The engine unpacks the entries one after another and runs the matching bus cycles. Read results go into a 16-byte read buffer. When the command ends, the engine raises a one-cycle completion pulse together with an error flag.

The register port is a plain request/acknowledge master. The engine holds the request, the address, the direction and the write data steady until the target acknowledges. On a read cycle, the target returns the byte alongside the acknowledge. A malformed command is refused as a whole before any bus cycle is issued.

Top module: `batch_reg_engine`

## Requirements
- R1: The command code selects the mode: 0 is write, 1 is read, 2 is read-modify-write. Any other code sets the error flag and issues no bus cycle. A read command never drives a write cycle.
- R2: Entries for read and write have a stride of 3 bytes. Entry n begins at buffer byte 3n, with the address low byte first and the address high byte next. In write mode, byte 3n+2 is the data byte written to that address.
- R3: Read-modify-write entries have a stride of 4 bytes, ordered address low, address high, data, mask. Each entry performs one read cycle and then one write cycle to the same address. The written value is (old AND NOT mask) OR (data AND mask).
- R4: The byte count must be the entry count times 3, or times 4 in read-modify-write mode. Any other count sets the error flag with no bus cycle.
- R5: A command with more than 5 entries, or whose byte count exceeds the 16-byte buffer, sets the error flag with no bus cycle.
- R6: In read mode, the byte read for entry n is stored at read-buffer byte 2+3n. The read buffer is cleared to zero whenever a command is accepted, so every other byte reads zero.
- R7: Entries are processed strictly in buffer order, one bus cycle at a time.
- R8: Completion is a single-cycle pulse on done, with err valid alongside it. With a target that acknowledges in the cycle after a request, done is high in the cycle after the (1+2N)th rising edge, counting from the edge that samples start, where N is the number of bus cycles.
- R9: A start that arrives while a command is in progress is ignored.
- R10: A byte count of zero completes with no bus cycle and no error, one edge after start.
- R11: After reset, done, err and reg_req are low and the read buffer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a command; honoured only while idle |
| cmd_id | input | 4 | Mode code (0 write, 1 read, 2 read-modify-write) |
| size | input | 8 | Byte count of the packed entries |
| wbuf | input | 128 | Write buffer; byte k is bits [8k+7:8k] |
| reg_req | output | 1 | Bus request, held until acknowledged |
| reg_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid with reg_ack |
| reg_ack | input | 1 | Target acknowledge |
| rbuf | output | 128 | Read buffer; byte k is bits [8k+7:8k] |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag for the finished command |

## Verification
A refused command or an empty command reports done one edge after start. A command with N bus cycles reports done 1+2N edges after start, because the bench's target acknowledges in the cycle after each request. The bench counts rising edges from the start edge and samples one time unit after each edge, so every timing check compares an exact edge count. Bus-side results are collected from the target model at each acknowledge edge and compared only after done. The read buffer and the error flag are sampled in the done cycle. A second sample one edge later confirms that done has dropped.

// File: rtl/batch_reg_pkg.sv
package batch_reg_pkg;
   localparam int ADDR_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_MERGE = 2'd2,
      OP_NONE  = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BUS  = 2'd1,
      ST_FIN  = 2'd2
   } state_e;
endpackage

// File: rtl/batch_size_check.sv
module batch_size_check
   import batch_reg_pkg::*;
#(
   parameter int SIZE_W      = 8,
   parameter int MAX_ENTRIES = 5,
   parameter int BUF_BYTES   = 16,
   parameter int CNT_W       = 3
) (
   input  op_e               op,
   input  logic [SIZE_W-1:0] size,
   output logic [CNT_W-1:0]  count,
   output logic              bad
);
   logic [SIZE_W-1:0] stride;
   logic [SIZE_W-1:0] quo;
   logic [SIZE_W-1:0] rem;

   always_comb begin
      stride = (op == OP_MERGE) ? SIZE_W'(4) : SIZE_W'(3);
      quo    = size / stride;
      rem    = size % stride;
      count  = CNT_W'(quo);
      bad    = (op == OP_NONE) || (rem != '0) ||
               (int'(quo) > MAX_ENTRIES) || (int'(size) > BUF_BYTES);
   end
endmodule

// File: rtl/batch_entry_pick.sv
module batch_entry_pick
   import batch_reg_pkg::*;
#(
   parameter int BUF_BYTES = 16,
   parameter int CNT_W     = 3
) (
   input  logic [BUF_BYTES*BYTE_W-1:0] buf_flat,
   input  logic [CNT_W-1:0]            idx,
   input  logic                        merge,
   output logic [ADDR_W-1:0]           addr,
   output logic [BYTE_W-1:0]           data,
   output logic [BYTE_W-1:0]           mask
);
   int base;
   logic [BYTE_W-1:0] lo_b, hi_b;

   always_comb begin
      base = int'(idx) * (merge ? 4 : 3);
      lo_b = '0;
      hi_b = '0;
      data = '0;
      mask = '0;
      for (int b = 0; b < BUF_BYTES; b++) begin
         if (b == base)     lo_b = buf_flat[b*BYTE_W +: BYTE_W];
         if (b == base + 1) hi_b = buf_flat[b*BYTE_W +: BYTE_W];
         if (b == base + 2) data = buf_flat[b*BYTE_W +: BYTE_W];
         if (b == base + 3) mask = buf_flat[b*BYTE_W +: BYTE_W];
      end
      addr = {hi_b, lo_b};
   end
endmodule

// File: rtl/batch_reg_engine.sv
module batch_reg_engine
   import batch_reg_pkg::*;
#(
   parameter int MAX_ENTRIES = 5,
   parameter int BUF_BYTES   = 16,
   parameter int SIZE_W      = 8,
   parameter int CMD_W       = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [CMD_W-1:0]            cmd_id,
   input  logic [SIZE_W-1:0]           size,
   input  logic [BUF_BYTES*8-1:0]      wbuf,
   output logic                        reg_req,
   output logic                        reg_we,
   output logic [15:0]                 reg_addr,
   output logic [7:0]                  reg_wdata,
   input  logic [7:0]                  reg_rdata,
   input  logic                        reg_ack,
   output logic [BUF_BYTES*8-1:0]      rbuf,
   output logic                        done,
   output logic                        err
);
   localparam int CNT_W = $clog2(MAX_ENTRIES + 1);

   initial begin
      assert (MAX_ENTRIES * 3 <= BUF_BYTES)
         else $error("entries do not fit the write buffer");
      assert (2 + 3 * (MAX_ENTRIES - 1) < BUF_BYTES)
         else $error("read slots do not fit the read buffer");
      assert ((1 << SIZE_W) > BUF_BYTES)
         else $error("size field too narrow");
   end

   state_e                 state_q;
   op_e                    op_q, op_in;
   logic [CNT_W-1:0]       cnt_q, idx_q, cnt_in;
   logic                   wr_phase_q, bad_in, err_q;
   logic [BYTE_W-1:0]      old_q;
   logic [BUF_BYTES*8-1:0] wbuf_q;
   logic [ADDR_W-1:0]      e_addr;
   logic [BYTE_W-1:0]      e_data, e_mask;
   logic                   start_acc;
   logic [BYTE_W-1:0]      slot_q [MAX_ENTRIES];

   always_comb begin
      case (cmd_id)
         CMD_W'(0): op_in = OP_WRITE;
         CMD_W'(1): op_in = OP_READ;
         CMD_W'(2): op_in = OP_MERGE;
         default:   op_in = OP_NONE;
      endcase
   end

   assign start_acc = (state_q == ST_IDLE) && start;

   batch_size_check #(
      .SIZE_W(SIZE_W), .MAX_ENTRIES(MAX_ENTRIES),
      .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
   ) u_size (
      .op(op_in), .size(size), .count(cnt_in), .bad(bad_in)
   );

   batch_entry_pick #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_pick (
      .buf_flat(wbuf_q), .idx(idx_q), .merge(op_q == OP_MERGE),
      .addr(e_addr), .data(e_data), .mask(e_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= OP_NONE;
         cnt_q      <= '0;
         idx_q      <= '0;
         wr_phase_q <= 1'b0;
         err_q      <= 1'b0;
         old_q      <= '0;
         wbuf_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               op_q       <= op_in;
               cnt_q      <= cnt_in;
               idx_q      <= '0;
               wbuf_q     <= wbuf;
               err_q      <= bad_in;
               wr_phase_q <= (op_in == OP_WRITE);
               state_q    <= (bad_in || cnt_in == '0) ? ST_FIN : ST_BUS;
            end
            ST_BUS: if (reg_ack) begin
               if (!wr_phase_q && op_q == OP_MERGE) begin
                  old_q      <= reg_rdata;
                  wr_phase_q <= 1'b1;
               end else if (idx_q + CNT_W'(1) == cnt_q) begin
                  state_q    <= ST_FIN;
                  wr_phase_q <= 1'b0;
               end else begin
                  idx_q      <= idx_q + CNT_W'(1);
                  wr_phase_q <= (op_q == OP_WRITE);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign reg_req   = (state_q == ST_BUS);
   assign reg_we    = wr_phase_q;
   assign reg_addr  = e_addr;
   assign reg_wdata = (op_q == OP_MERGE) ? ((old_q & ~e_mask) | (e_data & e_mask))
                                         : e_data;
   assign done      = (state_q == ST_FIN);
   assign err       = err_q;

   for (genvar n = 0; n < MAX_ENTRIES; n++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[n] <= '0;
         else if (start_acc)
            slot_q[n] <= '0;
         else if (reg_req && reg_ack && !wr_phase_q && op_q == OP_READ &&
                  idx_q == CNT_W'(n))
            slot_q[n] <= reg_rdata;
      end
   end

   always_comb begin
      rbuf = '0;
      for (int n = 0; n < MAX_ENTRIES; n++)
         rbuf[(2 + 3*n)*8 +: 8] = slot_q[n];
   end

   p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && op_q == OP_READ |-> !reg_we);
   p_merge_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_ack && !reg_we && op_q == OP_MERGE
      |=> reg_req && reg_we && $stable(reg_addr));
   p_err_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !reg_req);
   p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |-> (idx_q < cnt_q) && (int'(cnt_q) <= MAX_ENTRIES));
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we)
                              && $stable(reg_wdata));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != ST_IDLE && start |=> $stable(op_q) && $stable(cnt_q));
endmodule

// File: tb/batch_reg_engine_tb.sv
module batch_reg_engine_tb;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   cmd_id = '0;
   logic [7:0]   size = '0;
   logic [127:0] wbuf = '0;
   logic         reg_req, reg_we, reg_ack = 1'b0;
   logic [15:0]  reg_addr;
   logic [7:0]   reg_wdata, reg_rdata;
   logic [127:0] rbuf;
   logic         done, err;

   int checks = 0;
   int failures = 0;

   logic [7:0]  mem [256];
   int          n_acc = 0;
   logic [15:0] log_addr [16];
   logic        log_we   [16];
   logic [7:0]  log_data [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   batch_reg_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_id(cmd_id), .size(size),
      .wbuf(wbuf), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
      .rbuf(rbuf), .done(done), .err(err)
   );

   assign reg_rdata = reg_ack ? mem[reg_addr[7:0]] : 8'h00;

   always @(posedge clk) begin
      if (reg_req && reg_ack) begin
         if (n_acc < 16) begin
            log_addr[n_acc] = reg_addr;
            log_we[n_acc]   = reg_we;
            log_data[n_acc] = reg_we ? reg_wdata : reg_rdata;
         end
         if (reg_we) mem[reg_addr[7:0]] = reg_wdata;
         n_acc = n_acc + 1;
      end
      reg_ack <= reg_req && !reg_ack;
   end

   function automatic logic [7:0] init_val(input int i);
      return 8'(i) ^ 8'hC3;
   endfunction

   task automatic init_mem();
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
   endtask

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] c, input logic [7:0] s,
                      input logic [127:0] w, output int lat);
      n_acc = 0;
      @(negedge clk);
      cmd_id = c; size = s; wbuf = w; start = 1'b1;
      lat = 0;
      @(posedge clk);
      lat = 1;
      #1 start = 1'b0;
      while (!done && lat < 200) begin
         @(posedge clk);
         lat++;
         #1;
      end
   endtask

   task automatic after_done();
      @(posedge clk);
      #1 chk(!done, "R8 pulse", 128'(done), 128'd0);
   endtask

   typedef struct packed {
      logic [3:0]   cmd;
      logic [7:0]   sz;
      logic [127:0] wb;
      logic         e_err;
      logic [3:0]   e_acc;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{4'd0, 8'd3,  128'h5A1234,                            1'b0, 4'd1}, // R2 one write
      '{4'd0, 8'd15, 128'h0E0D0C0B0A0908070605040302010,     1'b0, 4'd5}, // R5 five writes
      '{4'd1, 8'd6,  128'h112233445566,                      1'b0, 4'd2}, // R1 read
      '{4'd2, 8'd16, 128'h00112233445566778899AABBCCDDEEFF,  1'b0, 4'd8}, // R3 four merges
      '{4'd0, 8'd4,  128'h01020304,                          1'b1, 4'd0}, // R4 ragged
      '{4'd2, 8'd6,  128'h01020304,                          1'b1, 4'd0}, // R4 ragged merge
      '{4'd0, 8'd18, 128'h1,                                 1'b1, 4'd0}, // R5 six entries
      '{4'd2, 8'd20, 128'h1,                                 1'b1, 4'd0}, // R5 over buffer
      '{4'd3, 8'd3,  128'h1,                                 1'b1, 4'd0}, // R1 bad code
      '{4'd15, 8'd3, 128'h1,                                 1'b1, 4'd0}, // R1 bad code
      '{4'd0, 8'd0,  128'h0,                                 1'b0, 4'd0}  // R10 empty
   };

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lat;
      logic [127:0] exp_rb;
      logic [7:0] e0, e1;
      int dones;
      init_mem();
      #(CLK_PERIOD * 3 + 2);
      // R11 reset state
      chk(!done && !err && !reg_req, "R11 outputs", {done, err, reg_req}, 0);
      chk(rbuf == '0, "R11 rbuf", rbuf, 0);
      rst_n = 1'b1;
      @(posedge clk);

      for (int v = 0; v < NV; v++) begin
         init_mem();
         run(VECS[v].cmd, VECS[v].sz, VECS[v].wb, lat);
         chk(err == VECS[v].e_err, "R1/R4/R5 err", 128'(err), 128'(VECS[v].e_err));
         chk(n_acc == int'(VECS[v].e_acc), "R4/R5 access count",
             128'(n_acc), 128'(VECS[v].e_acc));
         chk(lat == 1 + 2 * int'(VECS[v].e_acc), "R8 latency",
             128'(lat), 128'(1 + 2 * int'(VECS[v].e_acc)));
         after_done();
      end

      // R6 R7 R2: read three entries, ignored third bytes
      init_mem();
      run(4'd1, 8'd9, 128'hEE0005EE0120EE0010, lat);
      exp_rb = '0;
      exp_rb[2*8 +: 8] = init_val(8'h10);
      exp_rb[5*8 +: 8] = init_val(8'h20);
      exp_rb[8*8 +: 8] = init_val(8'h05);
      chk(rbuf == exp_rb, "R6 read slots", rbuf, exp_rb);
      chk(!err && n_acc == 3, "R1 read count", 128'(n_acc), 128'd3);
      chk(log_addr[0] == 16'h0010 && log_addr[1] == 16'h0120 && log_addr[2] == 16'h0005,
          "R7 read order", {log_addr[0], log_addr[1], log_addr[2]}, 48'h001001200005);
      chk(!log_we[0] && !log_we[1] && !log_we[2], "R1 read dir",
          {log_we[0], log_we[1], log_we[2]}, 0);
      after_done();

      // R2 R7: two writes, rbuf cleared at start (R6)
      init_mem();
      run(4'd0, 8'd6, 128'h990041770A40, lat);
      chk(rbuf == '0, "R6 cleared", rbuf, 0);
      chk(n_acc == 2 && log_we[0] && log_we[1], "R2 write count", 128'(n_acc), 128'd2);
      chk(log_addr[0] == 16'h0A40 && log_data[0] == 8'h77, "R2 entry0",
          {log_addr[0], log_data[0]}, 24'h0A4077);
      chk(log_addr[1] == 16'h0041 && log_data[1] == 8'h99, "R7 entry1",
          {log_addr[1], log_data[1]}, 24'h004199);
      chk(mem[8'h40] == 8'h77 && mem[8'h41] == 8'h99, "R2 target",
          {mem[8'h40], mem[8'h41]}, 16'h7799);
      after_done();

      // R3: two read-modify-write entries
      init_mem();
      e0 = (init_val(8'h50) & ~8'h0F) | (8'hAB & 8'h0F);
      e1 = (init_val(8'h51) & ~8'hF0) | (8'h12 & 8'hF0);
      run(4'd2, 8'd8, 128'hF0120051_0FAB0050, lat);
      chk(!err && n_acc == 4, "R3 count", 128'(n_acc), 128'd4);
      chk(!log_we[0] && log_we[1] && log_addr[0] == 16'h0050 && log_addr[1] == 16'h0050,
          "R3 rd then wr", {log_we[0], log_we[1], log_addr[0], log_addr[1]},
          {2'b01, 32'h00500050});
      chk(log_data[1] == e0, "R3 merge0", 128'(log_data[1]), 128'(e0));
      chk(!log_we[2] && log_we[3] && log_addr[3] == 16'h0051 && log_data[3] == e1,
          "R3 merge1", {log_we[3], log_addr[3], log_data[3]}, {1'b1, 16'h0051, e1});
      chk(lat == 9, "R8 merge latency", 128'(lat), 128'd9);
      after_done();

      // R9: start while busy is ignored
      init_mem();
      n_acc = 0;
      dones = 0;
      @(negedge clk);
      cmd_id = 4'd0; size = 8'd6; wbuf = 128'h220061110060; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      cmd_id = 4'd1; size = 8'd15; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(posedge clk);
         #1 if (done) dones++;
      end
      chk(dones == 1, "R9 one done", 128'(dones), 128'd1);
      chk(n_acc == 2 && log_we[0] && log_we[1], "R9 accesses", 128'(n_acc), 128'd2);
      chk(mem[8'h60] == 8'h11 && mem[8'h61] == 8'h22, "R9 data kept",
          {mem[8'h60], mem[8'h61]}, 16'h1122);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule